// File: doc/BRIEF.md
# Dual-Path SPI Shift-Clock Tick Generator

This block derives the timing strobes for an SPI shift engine from the source clock. It does not produce a real clock. It emits single-cycle enable ticks: one at every half SPI period and one at the end of every full period. The shift engine uses them to toggle its serial clock and to shift or capture data.

Two divider laws are available, and a select input chooses between them. The binary path divides the source by a fixed 4 and then by a power of two. The linear path divides by a fixed 2 and then by an integer (N+1). The chosen divider settings are latched at SPI period boundaries, so a running period always completes at the length it started with. The block also outputs the total divide ratio now in force, for the input-delay logic.

Top module: `spi_clk_tickgen`

## Requirements
- R1: With `lin_sel`=0 the total divide ratio is 4·2^`p2_exp` source cycles per SPI period, with `p2_exp` a 3-bit field (0→4, 1→8, 2→16, 3→32, up to 7→512).
- R2: With `lin_sel`=1 the total divide ratio is 2·(`lin_div`+1), with `lin_div` an 8-bit field (0→2, 255→512).
- R3: The field of the path that is not selected has no effect on the ratio or on the ticks.
- R4: While enabled, `half_tick` is high for exactly one cycle in every ratio/2 cycles.
- R5: `full_tick` is high only together with `half_tick`, on every second one, which marks the end of an SPI period.
- R6: After `enable` rises, the first `half_tick` comes in the cycle that completes ratio/2 enabled cycles. The first `full_tick` comes after a full ratio.
- R7: While `enable` is 0 both ticks stay low and the internal count restarts, so a new run follows R6.
- R8: A change to `lin_sel`, `p2_exp` or `lin_div` while enabled takes effect only after the next `full_tick`. The period in progress keeps its length, and `div_ratio` changes only at that boundary.
- R9: `div_ratio` gives the ratio in force. While disabled it follows the inputs one cycle later.
- R10: During synchronous reset both ticks are low and `div_ratio` is 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; 0 idles and restarts the count |
| lin_sel | input | 1 | 1 selects the linear path, 0 the binary path |
| p2_exp | input | 3 | Binary-path exponent N |
| lin_div | input | 8 | Linear-path divisor field N |
| half_tick | output | 1 | One-cycle strobe per half SPI period |
| full_tick | output | 1 | One-cycle strobe at the end of each SPI period |
| div_ratio | output | 10 | Total source cycles per SPI period now in force |

## Verification
Some rules are checked on every cycle. The count never reaches the half length. A half tick always returns the count to zero. A full tick always comes with a half tick. The reported ratio is even and at least 2. The ratio holds steady through a period unless the block is idle or a period has just ended. The divide laws themselves, the exact tick positions after enable, and the fact that a mid-period change waits for the boundary depend on particular input settings. Only the bench scenarios show those. They use directed corner settings (both path extremes, a change made inside a period, an edit to the field that is not selected) plus random settings checked against bench-computed ratios.

// File: rtl/spick_pkg.sv
package spick_pkg;

    localparam int P2_W    = 3;
    localparam int LIN_W   = 8;
    localparam int P2_PRE  = 4;
    localparam int LIN_PRE = 2;
    localparam int P2_BITS = (1 << P2_W) + 2;
    localparam int LIN_BITS = LIN_W + 2;
    localparam int RATIO_W = (P2_BITS > LIN_BITS) ? P2_BITS : LIN_BITS;
    localparam int HALF_W  = RATIO_W - 1;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [HALF_W-1:0]  half_t;

    typedef struct packed {
        logic             lin_sel;
        logic [P2_W-1:0]  p2_exp;
        logic [LIN_W-1:0] lin_div;
    } spick_cfg_t;

    function automatic ratio_t ratio_of(spick_cfg_t c);
        ratio_t r;
        if (c.lin_sel)
            r = ratio_t'(LIN_PRE) * (ratio_t'(c.lin_div) + ratio_t'(1));
        else
            r = ratio_t'(P2_PRE) << c.p2_exp;
        return r;
    endfunction

endpackage

// File: rtl/spick_cfg_hold.sv
module spick_cfg_hold
    import spick_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  spick_cfg_t cfg_in,
    output ratio_t     ratio,
    output half_t      half_len
);
    spick_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_in;
    end

    assign ratio    = ratio_of(cfg_q);
    assign half_len = ratio[RATIO_W-1:1];

endmodule

// File: rtl/spick_tick_ctr.sv
module spick_tick_ctr
    import spick_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  half_t half_len,
    output logic  half_tick,
    output logic  full_tick
);
    half_t cnt;
    logic  phase;
    logic  at_end;

    assign at_end = (cnt == half_len - half_t'(1));

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (at_end) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + half_t'(1);
        end
    end

    assign half_tick = enable && at_end;
    assign full_tick = half_tick && phase;

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        enable |-> (cnt < half_len));

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        half_tick |=> (cnt == '0));

    p_full_closes_r5: assert property (@(posedge clk) disable iff (rst)
        full_tick |=> !phase);

    p_idle_restart_r7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt == '0 && !phase && !full_tick));

endmodule

// File: rtl/spi_clk_tickgen.sv
module spi_clk_tickgen
    import spick_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               lin_sel,
    input  logic [P2_W-1:0]    p2_exp,
    input  logic [LIN_W-1:0]   lin_div,
    output logic               half_tick,
    output logic               full_tick,
    output logic [RATIO_W-1:0] div_ratio
);
    spick_cfg_t cfg_in;
    half_t      half_len;
    logic       load;

    assign cfg_in = '{lin_sel: lin_sel, p2_exp: p2_exp, lin_div: lin_div};
    assign load   = !enable || full_tick;

    spick_cfg_hold u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .cfg_in   (cfg_in),
        .ratio    (div_ratio),
        .half_len (half_len)
    );

    spick_tick_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .half_len  (half_len),
        .half_tick (half_tick),
        .full_tick (full_tick)
    );

    p_ratio_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !$past(full_tick)) |-> $stable(div_ratio));

    p_ratio_even_r1: assert property (@(posedge clk) disable iff (rst)
        (div_ratio[0] == 1'b0) && (div_ratio >= ratio_t'(2)));

    p_full_with_half_r5: assert property (@(posedge clk) disable iff (rst)
        full_tick |-> half_tick);

endmodule

// File: tb/tb_spi_clk_tickgen.sv
module tb_spi_clk_tickgen;
    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic       lin_sel;
    logic [2:0] p2_exp;
    logic [7:0] lin_div;
    logic       half_tick;
    logic       full_tick;
    logic [9:0] div_ratio;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int seed   = 32'h5A17;

    always #4 clk = ~clk;

    spi_clk_tickgen dut (
        .clk(clk), .rst(rst), .enable(enable), .lin_sel(lin_sel),
        .p2_exp(p2_exp), .lin_div(lin_div),
        .half_tick(half_tick), .full_tick(full_tick), .div_ratio(div_ratio)
    );

    function automatic int exp_ratio(logic s, logic [2:0] e, logic [7:0] l);
        if (s) return 2 * (int'(l) + 1);
        return 4 * (1 << int'(e));
    endfunction

    task automatic chk(string req, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Runs nper periods from enable rise; sample j in 0.. counts enabled cycles.
    task automatic run_check(string req, int ratio, int nper);
        int h = ratio / 2;
        int bad_h = 0;
        int bad_f = 0;
        enable = 1'b1;
        #1;
        for (int j = 0; j < ratio * nper; j++) begin
            if (j > 0) begin @(negedge clk); #1; end
            if (half_tick != (((j + 1) % h) == 0)) bad_h++;
            if (full_tick != (((j + 1) % ratio) == 0)) bad_f++;
        end
        chk(req, bad_h, 0, "half_tick mismatches");
        chk(req, bad_f, 0, "full_tick mismatches");
        @(negedge clk);
        enable = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 150000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; enable = 1'b0; lin_sel = 1'b1; p2_exp = 3'd5; lin_div = 8'd9;
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        chk("R10", int'(half_tick), 0, "half_tick in reset");
        chk("R10", int'(full_tick), 0, "full_tick in reset");
        chk("R10", int'(div_ratio), 4, "div_ratio in reset");
        @(negedge clk);
        rst = 1'b0;

        // R9: tracks inputs while idle; R7: ticks low while idle
        @(negedge clk); #1;
        chk("R9", int'(div_ratio), 20, "idle ratio follows inputs");
        repeat (30) begin
            @(negedge clk); #1;
            if (half_tick || full_tick)
                chk("R7", 1, 0, "tick while disabled");
        end
        chk("R7", int'(half_tick | full_tick), 0, "ticks idle");

        // R1 corners
        @(negedge clk); lin_sel = 1'b0; p2_exp = 3'd0;
        @(negedge clk); #1;
        chk("R1", int'(div_ratio), 4, "binary N=0");
        run_check("R1", 4, 3);
        @(negedge clk); p2_exp = 3'd7;
        @(negedge clk); #1;
        chk("R1", int'(div_ratio), 512, "binary N=7");
        run_check("R1", 512, 2);

        // R2 corners
        @(negedge clk); lin_sel = 1'b1; lin_div = 8'd0;
        @(negedge clk); #1;
        chk("R2", int'(div_ratio), 2, "linear N=0");
        run_check("R2", 2, 4);
        @(negedge clk); lin_div = 8'd255;
        @(negedge clk); #1;
        chk("R2", int'(div_ratio), 512, "linear N=255");

        // R3: unselected field has no effect
        @(negedge clk); lin_sel = 1'b0; p2_exp = 3'd1; lin_div = 8'd3;
        @(negedge clk); #1;
        chk("R3", int'(div_ratio), 8, "binary before lin edit");
        lin_div = 8'd77;
        @(negedge clk); #1;
        chk("R3", int'(div_ratio), 8, "lin_div ignored on binary path");
        run_check("R3", 8, 2);
        @(negedge clk); lin_sel = 1'b1; lin_div = 8'd4; p2_exp = 3'd6;
        @(negedge clk); #1;
        chk("R3", int'(div_ratio), 10, "p2_exp ignored on linear path");

        // R8: mid-period change waits for the boundary
        @(negedge clk); lin_sel = 1'b0; p2_exp = 3'd1;
        @(negedge clk); #1;
        enable = 1'b1;
        #0;
        begin
            int first_half = -1;
            int halves[4];
            int nh = 0;
            int fulls[2];
            int nf = 0;
            for (int j = 0; j < 16; j++) begin
                if (j > 0) begin @(negedge clk); #1; end
                if (half_tick && nh < 4) begin halves[nh] = j; nh++; end
                if (full_tick && nf < 2) begin fulls[nf] = j; nf++; end
                if (j == 3) begin
                    first_half = int'(half_tick);
                    lin_sel = 1'b1; lin_div = 8'd2;
                end
                if (j == 5) chk("R8", int'(div_ratio), 8, "ratio kept mid-period");
                if (j == 8) chk("R8", int'(div_ratio), 6, "ratio after boundary");
            end
            chk("R6", first_half, 1, "first half tick at ratio/2");
            chk("R8", halves[1], 7, "old period end");
            chk("R8", halves[2], 10, "new half period");
            chk("R8", halves[3], 13, "new period end");
            chk("R5", fulls[0], 7, "first full tick");
            chk("R5", fulls[1], 13, "second full tick");
        end
        @(negedge clk); enable = 1'b0;

        // R7: restart after disable follows R6
        @(negedge clk); lin_sel = 1'b1; lin_div = 8'd5;
        @(negedge clk); #1;
        run_check("R7", 12, 2);

        // Random settings: R4 R5 R6 R9
        for (int k = 0; k < 24; k++) begin
            logic s;
            logic [2:0] e;
            logic [7:0] l;
            int r;
            s = 1'($urandom(seed + k));
            e = 3'($urandom());
            l = 8'($urandom() % 64);
            r = exp_ratio(s, e, l);
            @(negedge clk); lin_sel = s; p2_exp = e; lin_div = l;
            @(negedge clk); #1;
            chk("R9", int'(div_ratio), r, "random ratio");
            run_check("R4", r, 2);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule